// File: doc/BRIEF.md
# CAN Transmit Error Monitor

This block watches a CAN transmitter while it puts a frame on the bus. At each sample point the frame sequencer gives it three things: the bit it meant to send, the bit read back from the bus, and a code that says which frame field the bit belongs to. From these it detects three kinds of error:

- a bit error, where the bus level differs from the level sent;
- a form error, where a dominant level appears in a field whose form is fixed recessive;
- an acknowledge error, where no receiver pulled the acknowledge slot dominant.

Inside the arbitration field, comparison is masked. A recessive bit that is overwritten by a dominant one there is reported as lost arbitration, not as an error.

When the block detects an error it latches a flag and holds an abort request. It also gives a one-cycle pulse that tells the sequencer to start an error frame. The flags stay set until the sequencer acknowledges them. If an error was pending at that acknowledge, the block pulses a retransmission request for the same frame. While any flag is set, the block evaluates no further bits. The first event in a frame is therefore the one that is reported.

Top module: `can_tx_err_monitor`

## Requirements
- R1: The field code is 4 bits: SOF=0, ARB=1, CTRL=2, DATA=3, CRC=4, CRC_DELIM=5, ACK_SLOT=6, ACK_DELIM=7, EOF=8, IFS=9. Codes 10 to 15 are never checked. Dominant is 0 and recessive is 1. A bit is evaluated only in a cycle where `sample_en` is 1; in any other cycle nothing changes.
- R2: A dominant `rx_bit` sampled in CRC_DELIM sets `form_err` at the next clock edge.
- R3: A dominant `rx_bit` sampled in ACK_DELIM, EOF or IFS also sets `form_err`.
- R4: In SOF, CTRL, DATA or CRC, an `rx_bit` that differs from `tx_bit` sets `bit_err`.
- R5: In ARB, a dominant bit sent and a recessive bit read back is not an error.
- R6: In ARB, a recessive bit sent and a dominant bit read back sets `arb_lost`. It raises neither `abort_req` nor `err_frame_start`.
- R7: A recessive `rx_bit` in ACK_SLOT sets `ack_err`. A dominant `rx_bit` in ACK_SLOT is accepted.
- R8: `abort_req` is 1 exactly while one of the three error flags is set. `err_frame_start` is 1 for the single cycle after the edge that sets an error flag.
- R9: Flags hold until `flag_ack`. While any flag (including `arb_lost`) is set, sampled bits are ignored.
- R10: `flag_ack` clears all flags at the next edge. If an error flag was set, `retx_req` is 1 for that one following cycle. After a lost arbitration alone, `retx_req` stays 0.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Sample-point strobe |
| field | input | 4 | Field code of the current bit |
| tx_bit | input | 1 | Bit the transmitter drives |
| rx_bit | input | 1 | Bit sampled from the bus |
| flag_ack | input | 1 | Sequencer acknowledges and clears the flags |
| bit_err | output | 1 | Sticky bit error |
| form_err | output | 1 | Sticky form error |
| ack_err | output | 1 | Sticky missing-acknowledge error |
| arb_lost | output | 1 | Sticky lost-arbitration indication |
| abort_req | output | 1 | Abort transmission request |
| err_frame_start | output | 1 | One-cycle pulse to start an error frame |
| retx_req | output | 1 | One-cycle pulse requesting the same frame again |

## Verification
The bench first sends a clean frame with matching levels in every field, which must raise nothing.

It then tries each error class:
- Mismatches in SOF, CTRL and DATA, and a dominant level in each fixed recessive field, separate bit errors from form errors.
- Both mismatch directions in arbitration separate a masked difference from lost arbitration.
- Both levels in the acknowledge slot separate an acknowledged frame from an acknowledge error.

Mismatches with the strobe low, or with an unused field code, must leave every output at 0. A second error sent while a flag is held shows that the flag is sticky and that only the first event is recorded. Each acknowledge shows whether a retransmission is requested.

// File: rtl/can_tx_err_monitor.sv
module can_tx_err_monitor #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [FIELD_W-1:0] field,
  input  logic               tx_bit,
  input  logic               rx_bit,
  input  logic               flag_ack,
  output logic               bit_err,
  output logic               form_err,
  output logic               ack_err,
  output logic               arb_lost,
  output logic               abort_req,
  output logic               err_frame_start,
  output logic               retx_req
);
  localparam logic [FIELD_W-1:0] F_SOF       = FIELD_W'(0);
  localparam logic [FIELD_W-1:0] F_ARB       = FIELD_W'(1);
  localparam logic [FIELD_W-1:0] F_CTRL      = FIELD_W'(2);
  localparam logic [FIELD_W-1:0] F_DATA      = FIELD_W'(3);
  localparam logic [FIELD_W-1:0] F_CRC       = FIELD_W'(4);
  localparam logic [FIELD_W-1:0] F_CRC_DELIM = FIELD_W'(5);
  localparam logic [FIELD_W-1:0] F_ACK_SLOT  = FIELD_W'(6);
  localparam logic [FIELD_W-1:0] F_ACK_DELIM = FIELD_W'(7);
  localparam logic [FIELD_W-1:0] F_EOF       = FIELD_W'(8);
  localparam logic [FIELD_W-1:0] F_IFS       = FIELD_W'(9);

  logic busy, live, fixed_fld, cmp_fld;
  logic det_bit, det_form, det_ack, det_arb;

  assign busy      = bit_err | form_err | ack_err | arb_lost;
  assign live      = sample_en & ~busy & ~flag_ack;
  assign fixed_fld = (field == F_CRC_DELIM) | (field == F_ACK_DELIM) |
                     (field == F_EOF) | (field == F_IFS);
  assign cmp_fld   = (field == F_SOF) | (field == F_CTRL) |
                     (field == F_DATA) | (field == F_CRC);

  assign det_form = live & fixed_fld & ~rx_bit;
  assign det_bit  = live & cmp_fld & (rx_bit != tx_bit);
  assign det_ack  = live & (field == F_ACK_SLOT) & rx_bit;
  assign det_arb  = live & (field == F_ARB) & tx_bit & ~rx_bit;

  assign abort_req = bit_err | form_err | ack_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_err         <= 1'b0;
      form_err        <= 1'b0;
      ack_err         <= 1'b0;
      arb_lost        <= 1'b0;
      err_frame_start <= 1'b0;
      retx_req        <= 1'b0;
    end else if (flag_ack) begin
      bit_err         <= 1'b0;
      form_err        <= 1'b0;
      ack_err         <= 1'b0;
      arb_lost        <= 1'b0;
      err_frame_start <= 1'b0;
      retx_req        <= abort_req;
    end else begin
      bit_err         <= bit_err | det_bit;
      form_err        <= form_err | det_form;
      ack_err         <= ack_err | det_ack;
      arb_lost        <= arb_lost | det_arb;
      err_frame_start <= det_bit | det_form | det_ack;
      retx_req        <= 1'b0;
    end
  end

  assert_form_crc_delim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !busy && !flag_ack && field == F_CRC_DELIM && !rx_bit) |=> form_err);

  assert_arb_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !busy && field == F_ARB) |=> !bit_err && !err_frame_start);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !flag_ack) |=> $stable({bit_err, form_err, ack_err}));

  assert_single_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_err, form_err, ack_err, arb_lost}));

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame_start |=> !err_frame_start);

  assert_retx_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> !abort_req && !$past(retx_req));
endmodule

// File: tb/tb_can_tx_err_monitor.sv
module tb_can_tx_err_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_en = 1'b0, tx_bit = 1'b1, rx_bit = 1'b1, flag_ack = 1'b0;
  logic [3:0] field = 4'd0;
  logic bit_err, form_err, ack_err, arb_lost, abort_req, err_frame_start, retx_req;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  can_tx_err_monitor dut (.clk, .rst_n, .sample_en, .field, .tx_bit, .rx_bit,
    .flag_ack, .bit_err, .form_err, .ack_err, .arb_lost, .abort_req,
    .err_frame_start, .retx_req);

  function automatic logic [6:0] outs();
    return {bit_err, form_err, ack_err, arb_lost, abort_req, err_frame_start, retx_req};
  endfunction

  task automatic chk(string req, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: outputs got %b expected %b", req, got, exp);
    end
  endtask

  task automatic put(logic [3:0] f, logic t, logic r, logic en = 1'b1);
    field = f; tx_bit = t; rx_bit = r; sample_en = en;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic ack_and_check(string req, logic exp_retx);
    flag_ack = 1'b1;
    @(negedge clk);
    flag_ack = 1'b0;
    chk(req, outs(), {6'b0, exp_retx});
    @(negedge clk);
    chk(req, outs(), 7'b0);
  endtask

  task automatic t_reset();
    chk("R11", outs(), 7'b0);
  endtask

  task automatic t_clean_frame();
    put(4'd0, 0, 0); put(4'd1, 1, 1); put(4'd1, 0, 0); put(4'd2, 0, 0);
    put(4'd3, 1, 1); put(4'd4, 0, 0); put(4'd5, 1, 1); put(4'd6, 1, 0);
    put(4'd7, 1, 1); put(4'd8, 1, 1); put(4'd9, 1, 1);
    chk("R7 clean frame with dominant ack", outs(), 7'b0);
  endtask

  task automatic t_ignored();
    put(4'd3, 1, 0, 1'b0);
    chk("R1 strobe low", outs(), 7'b0);
    put(4'd12, 1, 0);
    put(4'd15, 0, 1);
    chk("R1 unused code", outs(), 7'b0);
  endtask

  task automatic t_bit_error(logic [3:0] f, logic t, logic r);
    put(f, t, r);
    chk("R4 R8 bit error", outs(), 7'b1000110);
    @(negedge clk);
    chk("R8 R9 pulse ends, flag holds", outs(), 7'b1000100);
    ack_and_check("R10 bit error retx", 1'b1);
  endtask

  task automatic t_sticky();
    put(4'd3, 0, 1);
    put(4'd5, 1, 0);
    put(4'd6, 1, 1);
    chk("R9 first error only", outs(), 7'b1000100);
    ack_and_check("R10", 1'b1);
  endtask

  task automatic t_form(string req, logic [3:0] f);
    put(f, 1, 0);
    chk(req, outs(), 7'b0100110);
    ack_and_check("R10 form retx", 1'b1);
  endtask

  task automatic t_arb();
    put(4'd1, 0, 1);
    chk("R5 dominant sent recessive read", outs(), 7'b0);
    put(4'd1, 1, 0);
    chk("R6 arbitration lost", outs(), 7'b0001000);
    put(4'd3, 1, 0);
    chk("R9 ignored after arb loss", outs(), 7'b0001000);
    ack_and_check("R10 no retx after arb loss", 1'b0);
  endtask

  task automatic t_ack();
    put(4'd6, 1, 1);
    chk("R7 missing ack", outs(), 7'b0010110);
    ack_and_check("R10 ack retx", 1'b1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_frame();
    t_ignored();
    t_bit_error(4'd3, 1, 0);
    t_bit_error(4'd0, 0, 1);
    t_bit_error(4'd2, 1, 0);
    t_sticky();
    t_form("R2 crc delimiter", 4'd5);
    t_form("R3 ack delimiter", 4'd7);
    t_form("R3 end of frame", 4'd8);
    t_form("R3 interframe", 4'd9);
    t_arb();
    t_ack();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule